// File: doc/BRIEF.md
# Burst SRAM Cycle Decoder

This block is the synchronous control front end of a flow-through burst static memory. On every rising clock edge it samples three chip enables, a processor-side and a controller-side address strobe, a burst advance input and the write enables. It classifies the cycle as deselect, begin read, begin write, continue or suspend. From that class it issues per-byte write strobes, a load-address pulse and an advance pulse, and it keeps the burst address up to date.

A byte-writable array of `DEPTH` words sits behind the decoder. Read data flows out combinationally in the same cycle that the address is registered. Write data is captured on the edge that samples the write and reaches the array on the following edge. The output-drive enable is the registered read state gated by an asynchronous output enable, so a host can release or take the bus without waiting for a clock.

Top module: `bsram_cycle_dec`

## Requirements
- R1: The device is selected only when `ce0_n_i`=0, `ce1_i`=1 and `ce2_n_i`=0. An accepted strobe while any of the three is inactive gives a deselect cycle (`cyc_o`=0). A deselect cycle has no byte strobes, no load or advance pulse, and the bus is released.
- R2: While `ce0_n_i`=1 the processor strobe is ignored. A low controller strobe then gives a deselect cycle. With the controller strobe high, the cycle is continue or suspend as if both strobes were high.
- R3: `pstb_n_i`=0 with all chip enables active begins a read at `addr_i` (`cyc_o`=1, `load_o`=1, `byte_we_o`=0), whatever the controller strobe and the write inputs are.
- R4: `cstb_n_i`=0 with `pstb_n_i`=1 and the device selected loads `addr_i`. The write inputs on that edge pick begin write (`cyc_o`=2) or begin read (`cyc_o`=1).
- R5: With both strobes effectively high during an active burst, `step_n_i`=0 gives continue (`cyc_o`=3, `adv_o`=1, next burst address) and `step_n_i`=1 gives suspend (`cyc_o`=4, same address). The chip enables do not matter here. If the device is deselected it stays deselected. `load_o` and `adv_o` are never high together.
- R6: Byte strobe mask: `wr_all_n_i`=0 gives 4'b1111. Otherwise, with `wr_byte_n_i`=0 the mask is `~byte_en_n_i` (bit n is byte n, bits [8n+7:8n]). Otherwise the mask is 0. A cycle with an all-zero mask is a read.
- R7: `drive_o` is 1 only in a read cycle with `out_en_n_i`=0. It follows `out_en_n_i` without a clock edge, and it is 0 in any write cycle.
- R8: Burst order uses the two low address bits. With `burst_lin_i`=1 the k-th access is at (start+k) mod 4. With `burst_lin_i`=0 it is at start XOR k. The upper address bits stay fixed.
- R9: `rdata_o` is the array word at the current cycle's address, valid in the cycle after the edge that registered it. A written byte reads back in any read cycle that starts on or after the edge following the write.
- R10: While `rst_ni`=0 (asynchronous), the block is deselected: `cyc_o`=0, `byte_we_o`=0, `load_o`=0, `adv_o`=0 and `drive_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce0_n_i | input | 1 | Master chip enable, active low; gates the processor strobe |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_n_i | input | 1 | Chip enable, active low |
| pstb_n_i | input | 1 | Processor address strobe, active low |
| cstb_n_i | input | 1 | Controller address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low |
| wr_all_n_i | input | 1 | Write all bytes, active low |
| wr_byte_n_i | input | 1 | Byte-write qualifier, active low |
| byte_en_n_i | input | NB | Per-byte write enables, active low |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr_i | input | AW | External word address |
| wdata_i | input | DW | Write data |
| cyc_o | output | 3 | Cycle class of the current cycle |
| byte_we_o | output | NB | Per-byte write strobes of the current cycle |
| load_o | output | 1 | Pulse: external address loaded |
| adv_o | output | 1 | Pulse: burst address advanced |
| drive_o | output | 1 | Data bus drive enable |
| rdata_o | output | DW | Flow-through read data |

## Verification
Cycle class, byte strobes and the load and advance pulses are due one edge after the inputs are sampled. The bench applies each vector at a falling edge and compares the outputs at the next falling edge, while that vector's inputs are still held. Read data is due in the same cycle as those outputs. A write reaches the array one edge later, so read-back checks always start a fresh read after the write cycle. `drive_o` is checked 1 ns after `out_en_n_i` or `rst_ni` changes, with no clock edge in between.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [2:0] {
    CYC_DESEL    = 3'd0,
    CYC_RD_BEGIN = 3'd1,
    CYC_WR_BEGIN = 3'd2,
    CYC_CONT     = 3'd3,
    CYC_SUSP     = 3'd4
  } cyc_e;
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode #(
  parameter int NB = 4
) (
  input  logic             ce0_n_i,
  input  logic             ce1_i,
  input  logic             ce2_n_i,
  input  logic             pstb_n_i,
  input  logic             cstb_n_i,
  input  logic             step_n_i,
  input  logic             wr_all_n_i,
  input  logic             wr_byte_n_i,
  input  logic [NB-1:0]    byte_en_n_i,
  input  logic             burst_act_i,
  output bsram_pkg::cyc_e  cyc_o,
  output logic [NB-1:0]    we_o,
  output logic             load_o,
  output logic             step_o,
  output logic             rd_o
);
  import bsram_pkg::*;

  logic          sel;
  logic          pstb_live;
  logic [NB-1:0] mask;
  logic          wr;

  always_comb begin
    sel       = !ce0_n_i && ce1_i && !ce2_n_i;
    pstb_live = !pstb_n_i && !ce0_n_i;  // master enable gates processor strobe
    if (!wr_all_n_i)      mask = '1;
    else if (wr_byte_n_i) mask = '0;
    else                  mask = ~byte_en_n_i;
    wr = |mask;

    cyc_o  = CYC_DESEL;
    we_o   = '0;
    load_o = 1'b0;
    step_o = 1'b0;
    rd_o   = 1'b0;

    if (pstb_live) begin
      if (sel) begin
        cyc_o  = CYC_RD_BEGIN;  // write inputs ignored here
        load_o = 1'b1;
        rd_o   = 1'b1;
      end
    end else if (!cstb_n_i) begin
      if (sel) begin
        load_o = 1'b1;
        if (wr) begin
          cyc_o = CYC_WR_BEGIN;
          we_o  = mask;
        end else begin
          cyc_o = CYC_RD_BEGIN;
          rd_o  = 1'b1;
        end
      end
    end else if (burst_act_i) begin
      cyc_o  = step_n_i ? CYC_SUSP : CYC_CONT;
      step_o = !step_n_i;
      we_o   = mask;
      rd_o   = !wr;
    end
  end
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst #(
  parameter int AW    = 6,
  parameter int BURST = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic          lin_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  localparam int CW = $clog2(BURST);

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  // offset never carries into the upper bits
  always_comb lo = lin_i ? (base_q[CW-1:0] + cnt_q) : (base_q[CW-1:0] ^ cnt_q);
  assign addr_o = {base_q[AW-1:CW], lo};

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i)); // R8
  AST_STEP_KEEPS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> $stable(addr_o[AW-1:CW])); // R8
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int NB    = 4
) (
  input  logic                     clk_i,
  input  logic [NB-1:0]            we_i,
  input  logic [$clog2(DEPTH)-1:0] addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int BW = DW / NB;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[b]) lane[addr_i] <= wdata_i[b*BW +: BW];
    end
    assign rdata_o[b*BW +: BW] = lane[addr_i];
  end
endmodule

// File: rtl/bsram_cycle_dec.sv
module bsram_cycle_dec #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int NB    = 4,
  parameter int BURST = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce0_n_i,
  input  logic          ce1_i,
  input  logic          ce2_n_i,
  input  logic          pstb_n_i,
  input  logic          cstb_n_i,
  input  logic          step_n_i,
  input  logic          wr_all_n_i,
  input  logic          wr_byte_n_i,
  input  logic [NB-1:0] byte_en_n_i,
  input  logic          out_en_n_i,
  input  logic          burst_lin_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [2:0]    cyc_o,
  output logic [NB-1:0] byte_we_o,
  output logic          load_o,
  output logic          adv_o,
  output logic          drive_o,
  output logic [DW-1:0] rdata_o
);
  import bsram_pkg::*;

  cyc_e          cyc_d, cyc_q;
  logic [NB-1:0] we_d, we_q;
  logic          load_d, step_d, rd_d;
  logic          load_q, adv_q, rd_q;
  logic [DW-1:0] wdata_q;
  logic [AW-1:0] cur_addr;

  bsram_decode #(.NB(NB)) u_decode (
    .ce0_n_i     (ce0_n_i),
    .ce1_i       (ce1_i),
    .ce2_n_i     (ce2_n_i),
    .pstb_n_i    (pstb_n_i),
    .cstb_n_i    (cstb_n_i),
    .step_n_i    (step_n_i),
    .wr_all_n_i  (wr_all_n_i),
    .wr_byte_n_i (wr_byte_n_i),
    .byte_en_n_i (byte_en_n_i),
    .burst_act_i (cyc_q != CYC_DESEL),
    .cyc_o       (cyc_d),
    .we_o        (we_d),
    .load_o      (load_d),
    .step_o      (step_d),
    .rd_o        (rd_d)
  );

  bsram_burst #(.AW(AW), .BURST(BURST)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_d),
    .step_i (step_d),
    .lin_i  (burst_lin_i),
    .addr_i (addr_i),
    .addr_o (cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= CYC_DESEL;
      we_q   <= '0;
      load_q <= 1'b0;
      adv_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      we_q   <= we_d;
      load_q <= load_d;
      adv_q  <= step_d;
      rd_q   <= rd_d;
    end
  end

  // data captured with the write; committed on the next edge at the cycle address
  always_ff @(posedge clk_i) begin
    if (|we_d) wdata_q <= wdata_i;
  end

  bsram_array #(.DW(DW), .DEPTH(DEPTH), .NB(NB)) u_array (
    .clk_i   (clk_i),
    .we_i    (we_q),
    .addr_i  (cur_addr),
    .wdata_i (wdata_q),
    .rdata_o (rdata_o)
  );

  assign cyc_o     = cyc_q;
  assign byte_we_o = we_q;
  assign load_o    = load_q;
  assign adv_o     = adv_q;
  assign drive_o   = rd_q && !out_en_n_i;

  logic sel_in;
  assign sel_in = !ce0_n_i && ce1_i && !ce2_n_i;

  AST_UNSEL_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_in && (!cstb_n_i || (!pstb_n_i && !ce0_n_i))) |=> cyc_o == 3'(CYC_DESEL)); // R1
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_o == 3'(CYC_DESEL)) |-> (byte_we_o == '0 && !load_o && !adv_o && !drive_o)); // R1
  AST_CE0_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce0_n_i && !cstb_n_i) |=> cyc_o == 3'(CYC_DESEL)); // R2
  AST_PSTB_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pstb_n_i && sel_in) |=> (cyc_o == 3'(CYC_RD_BEGIN) && byte_we_o == '0 && load_o)); // R3
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_o, adv_o})); // R5
  AST_WR_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|byte_we_o) |-> !drive_o); // R7
endmodule

// File: tb/bsram_cycle_dec_tb.sv
module bsram_cycle_dec_tb;
  import bsram_pkg::*;

  localparam int DW = 32, DEPTH = 64, NB = 4, AW = 6, NV = 15;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_ni, ce0_n, ce1, ce2_n, pstb_n, cstb_n, step_n, wall_n, wbyte_n, oe_n, lin;
  logic [NB-1:0] be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [2:0]    cyc;
  logic [NB-1:0] bwe;
  logic          ld, adv, drv;
  logic [DW-1:0] rdata;

  bsram_cycle_dec u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce0_n_i(ce0_n), .ce1_i(ce1), .ce2_n_i(ce2_n),
    .pstb_n_i(pstb_n), .cstb_n_i(cstb_n), .step_n_i(step_n), .wr_all_n_i(wall_n),
    .wr_byte_n_i(wbyte_n), .byte_en_n_i(be_n), .out_en_n_i(oe_n), .burst_lin_i(lin),
    .addr_i(addr), .wdata_i(wdata), .cyc_o(cyc), .byte_we_o(bwe), .load_o(ld),
    .adv_o(adv), .drive_o(drv), .rdata_o(rdata)
  );

  // {ce0_n,ce1,ce2_n,pstb_n,cstb_n,step_n,wall_n,wbyte_n,be_n[3:0],oe_n | cyc,we[3:0],ld,adv,drv}
  localparam logic [22:0] VEC [NV] = '{
    23'b0_1_0_0_1_1_0_1_1111_0_001_0000_1_0_1, // 0  R3 pstb read, write ignored
    23'b0_1_0_1_1_0_1_1_1111_0_011_0000_0_1_1, // 1  R5 continue read
    23'b1_1_0_1_1_1_1_1_1111_0_100_0000_0_0_1, // 2  R5 suspend, ce don't care
    23'b0_1_0_1_1_0_0_1_1111_0_011_1111_0_1_0, // 3  R7 continue write, bus off
    23'b0_1_0_1_0_1_1_0_1010_0_010_0101_1_0_0, // 4  R4 cstb byte write
    23'b0_1_0_1_0_1_1_0_1111_1_001_0000_1_0_0, // 5  R6 no byte enabled -> read
    23'b1_1_0_0_0_1_1_1_1111_0_000_0000_0_0_0, // 6  R2 ce0 off, cstb -> deselect
    23'b0_1_0_1_1_0_1_1_1111_0_000_0000_0_0_0, // 7  R5 deselected stays
    23'b0_0_0_0_1_1_1_1_1111_0_000_0000_0_0_0, // 8  R1 ce1 inactive
    23'b0_1_0_0_1_1_1_1_1111_1_001_0000_1_0_0, // 9  R3 read, oe high
    23'b1_1_0_0_1_0_1_1_1111_0_011_0000_0_1_1, // 10 R2 pstb blocked -> continue
    23'b0_1_0_0_0_1_0_1_1111_0_001_0000_1_0_1, // 11 R3 pstb wins over cstb write
    23'b0_1_1_1_0_1_1_1_1111_0_000_0000_0_0_0, // 12 R1 ce2 inactive
    23'b0_1_0_1_0_1_0_1_1111_0_010_1111_1_0_0, // 13 R6 write all
    23'b0_1_0_1_1_1_1_0_0111_0_100_1000_0_0_0  // 14 R6 suspend byte write
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_mem [DEPTH];

  function automatic string vreq(input int i);
    case (i)
      0, 9, 11:  return "R3";
      1, 2, 7:   return "R5";
      3:         return "R7";
      4:         return "R4";
      5, 13, 14: return "R6";
      6, 10:     return "R2";
      default:   return "R1";
    endcase
  endfunction

  function automatic logic [DW-1:0] dval(input int a);
    return 32'hC0DE_0000 | DW'(a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce0_n = 0; ce1 = 1; ce2_n = 0; pstb_n = 1; cstb_n = 1; step_n = 1;
    wall_n = 1; wbyte_n = 1; be_n = '1; oe_n = 1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_ni = 0; idle(); lin = 1; addr = '0; wdata = '0; oe_n = 0;
    repeat (3) @(negedge clk);
    chk("R10", 32'(cyc), 0); chk("R10", 32'(bwe), 0);
    chk("R10", {ld, adv, drv}, 0);
    rst_ni = 1;

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      {ce0_n, ce1, ce2_n, pstb_n, cstb_n, step_n, wall_n, wbyte_n} = v[22:15];
      be_n = v[14:11]; oe_n = v[10];
      tick();
      chk(vreq(i), 32'(cyc), 32'(v[9:7]));
      chk(vreq(i), 32'(bwe), 32'(v[6:3]));
      chk(vreq(i), {ld, adv, drv}, 32'(v[2:0]));
    end

    // linear burst write at 8..11
    idle(); lin = 1; cstb_n = 0; wall_n = 0; addr = 6'd8; wdata = dval(8);
    tick(); exp_mem[8] = dval(8);
    chk("R4", 32'(cyc), 32'(CYC_WR_BEGIN)); chk("R6", 32'(bwe), 32'hF);
    cstb_n = 1; step_n = 0;
    for (int k = 1; k < 4; k++) begin
      wdata = dval(8 + k);
      tick(); exp_mem[8 + k] = dval(8 + k);
      chk("R5", {29'd0, cyc}, 32'(CYC_CONT)); chk("R5", 32'(adv), 1);
    end

    // linear read burst from 9: 9,10,11,8
    idle(); pstb_n = 0; addr = 6'd9; oe_n = 0;
    tick(); chk("R9", rdata, exp_mem[9]); chk("R7", 32'(drv), 1);
    pstb_n = 1; step_n = 0;
    for (int k = 1; k < 4; k++) begin
      tick(); chk("R8", rdata, exp_mem[8 + ((1 + k) % 4)]);
    end
    step_n = 1;
    tick(); chk("R5", rdata, exp_mem[8]);

    // interleaved read burst from 9: 9,8,11,10
    lin = 0; pstb_n = 0; addr = 6'd9;
    tick(); chk("R8", rdata, exp_mem[9]);
    pstb_n = 1; step_n = 0;
    for (int k = 1; k < 4; k++) begin
      tick(); chk("R8", rdata, exp_mem[8 + (1 ^ k)]);
    end

    // single byte write, then read back
    idle(); cstb_n = 0; wbyte_n = 0; be_n = 4'b1110; addr = 6'd9; wdata = 32'h1122_3344; oe_n = 0;
    tick(); exp_mem[9][7:0] = 8'h44;
    chk("R6", 32'(bwe), 32'h1); chk("R7", 32'(drv), 0);
    idle(); pstb_n = 0; addr = 6'd9; oe_n = 0;
    tick(); chk("R9", rdata, exp_mem[9]);

    // output enable acts without a clock
    oe_n = 1; #1 chk("R7", 32'(drv), 0);
    oe_n = 0; #1 chk("R7", 32'(drv), 1);

    // asynchronous reset mid-burst
    pstb_n = 1; rst_ni = 0; #1
    chk("R10", 32'(drv), 0); chk("R10", 32'(cyc), 0);
    @(negedge clk); rst_ni = 1; step_n = 0;
    tick(); chk("R5", 32'(cyc), 32'(CYC_DESEL));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule